// File: doc/BRIEF.md
# Optical Low-Light Link Monitor

This block judges whether a fiber receiver is seeing a usable optical signal. It watches two digital inputs. The first is the sliced output of the receive quantizer. The second is a flag from the analog level comparator that is high while the received amplitude is above the detection threshold. From these it drives a single active-low monitor output, which is low only while the optical link is judged good.

Loss is declared on two separate time scales. When transitions stop (no light), the monitor reacts within a few microseconds. When only the amplitude sags below threshold, the monitor waits about a hundred microseconds before it reacts. After any loss, the monitor returns to good only after a long, unbroken qualification interval of good signal, about half a second. Any interruption during that interval starts it again from zero.

Both inputs are asynchronous to the system clock and pass through two-flop synchronisers. Every time constant is a parameter counted in system clock ticks.

Top module: `optmon_top`

## Requirements
- R1: While reset is asserted and after reset is released, the monitor output `mon_n_o` is high (link not good) until a full qualification has completed.
- R2: `mon_n_o` falls only after RECOVER_TICKS consecutive clock ticks in which transitions are present and the synchronised amplitude flag is high.
- R3: Transitions are treated as present as long as successive quantizer changes are spaced fewer than GAP_TICKS clock ticks apart, so a good link stays good under such spacing.
- R4: Once the link is good, if the quantizer input stops changing, `mon_n_o` rises exactly GAP_TICKS+3 clock edges after the edge that first samples the last change. That count covers two synchroniser stages and one edge-detect register.
- R5: Once the link is good, if the amplitude flag goes low and stays low, `mon_n_o` rises exactly AMP_LOSS_TICKS+2 clock edges after the edge that first samples the low flag. A low stretch shorter than that leaves the output low.
- R6: During qualification, any tick without transitions or without the amplitude flag clears the recovery count. Qualification then needs a fresh, full RECOVER_TICKS run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quant_i | input | 1 | Asynchronous quantizer data (optical receive slice) |
| above_i | input | 1 | Asynchronous amplitude-above-threshold flag, high = enough light |
| mon_n_o | output | 1 | Active-low link monitor: 0 = optical link good, 1 = low light / no light |

## Verification
On every cycle, the embedded assertions check the following:
- A missing-transition indication or an expired amplitude timer forces the output high on the next cycle.
- A detected quantizer change keeps transitions present on the next cycle.
- Every interrupted qualification tick leaves the recovery count at zero.
- The output falls only after a tick of good signal.

Only the bench's scenarios can show the exact latencies through the synchronisers, that short amplitude dips are ignored, and that a restarted qualification really needs a fresh full interval. The bench shows these by comparing against a behavioural model on every clock and by checking the edge counts directly.

// File: rtl/optmon_pkg.sv
package optmon_pkg;

    typedef enum logic {
        LINK_DOWN = 1'b0,
        LINK_UP   = 1'b1
    } link_e;

endpackage

// File: rtl/optmon_sync.sv
module optmon_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_i;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.stable;

endmodule

// File: rtl/optmon_activity.sv
module optmon_activity #(
    parameter int GAP_TICKS = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic trans_ok_o
);

    localparam int GW = $clog2(GAP_TICKS + 1);
    localparam logic [GW-1:0] GAP_MAX = GW'(GAP_TICKS);

    typedef struct packed {
        logic          prev;
        logic [GW-1:0] gap;
    } act_t;

    act_t a_d, a_q;
    logic edge_seen;

    assign edge_seen = lvl_i ^ a_q.prev;

    always_comb begin
        a_d      = a_q;
        a_d.prev = lvl_i;
        if (edge_seen)              a_d.gap = '0;
        else if (a_q.gap < GAP_MAX) a_d.gap = a_q.gap + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q.prev <= 1'b0;
            a_q.gap  <= GAP_MAX;
        end else begin
            a_q <= a_d;
        end
    end

    assign trans_ok_o = (a_q.gap < GAP_MAX);

    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> trans_ok_o);

endmodule

// File: rtl/optmon_amp.sv
module optmon_amp #(
    parameter int AMP_LOSS_TICKS = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bright_i,
    output logic dim_lost_o
);

    localparam int AW = $clog2(AMP_LOSS_TICKS + 1);
    localparam logic [AW-1:0] AMP_MAX = AW'(AMP_LOSS_TICKS);

    typedef struct packed {
        logic [AW-1:0] dark;
    } amp_t;

    amp_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (bright_i)               m_d.dark = '0;
        else if (m_q.dark < AMP_MAX) m_d.dark = m_q.dark + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign dim_lost_o = (m_q.dark >= AMP_MAX);

    // R5
    dim_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bright_i |=> !dim_lost_o);

endmodule

// File: rtl/optmon_qual.sv
module optmon_qual
    import optmon_pkg::*;
#(
    parameter int RECOVER_TICKS = 100000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trans_ok_i,
    input  logic bright_i,
    input  logic dim_lost_i,
    output logic mon_n_o
);

    localparam int RW = (RECOVER_TICKS > 2) ? $clog2(RECOVER_TICKS) : 1;
    localparam logic [RW-1:0] REC_LAST = RW'(RECOVER_TICKS - 1);

    typedef struct packed {
        link_e         link;
        logic [RW-1:0] rec;
    } qual_t;

    qual_t q_d, q_q;
    logic  sig_good;

    assign sig_good = trans_ok_i && bright_i;

    always_comb begin
        q_d = q_q;
        if (q_q.link == LINK_UP) begin
            if (!trans_ok_i || dim_lost_i) begin
                q_d.link = LINK_DOWN;
                q_d.rec  = '0;
            end
        end else if (sig_good) begin
            if (q_q.rec == REC_LAST) begin
                q_d.link = LINK_UP;
                q_d.rec  = '0;
            end else begin
                q_d.rec = q_q.rec + 1'b1;
            end
        end else begin
            q_d.rec = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q.link <= LINK_DOWN;
            q_q.rec  <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign mon_n_o = (q_q.link != LINK_UP);

    // R4
    no_light_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trans_ok_i |=> mon_n_o);

    // R5
    low_light_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dim_lost_i && !mon_n_o) |=> mon_n_o);

    // R2
    rise_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mon_n_o) |-> $past(sig_good));

    // R6
    qual_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_n_o && !sig_good) |=> (q_q.rec == '0));

endmodule

// File: rtl/optmon_top.sv
module optmon_top #(
    parameter int GAP_TICKS      = 600,
    parameter int AMP_LOSS_TICKS = 20000,
    parameter int RECOVER_TICKS  = 100000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic quant_i,
    input  logic above_i,
    output logic mon_n_o
);

    logic [1:0] raw_in;
    logic [1:0] sync_in;
    logic       trans_ok;
    logic       dim_lost;

    assign raw_in = {above_i, quant_i};

    optmon_sync #(.WIDTH(2)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    optmon_activity #(.GAP_TICKS(GAP_TICKS)) activity_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (sync_in[0]),
        .trans_ok_o (trans_ok)
    );

    optmon_amp #(.AMP_LOSS_TICKS(AMP_LOSS_TICKS)) amp_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bright_i   (sync_in[1]),
        .dim_lost_o (dim_lost)
    );

    optmon_qual #(.RECOVER_TICKS(RECOVER_TICKS)) qual_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .trans_ok_i (trans_ok),
        .bright_i   (sync_in[1]),
        .dim_lost_i (dim_lost),
        .mon_n_o    (mon_n_o)
    );

    // R1
    reset_down_chk: assert property (@(posedge clk)
        !rst_n |=> mon_n_o);

endmodule

// File: tb/optmon_top_tb.sv
`timescale 1ns/1ps
module optmon_top_tb_top;

    localparam int G = 8;
    localparam int A = 20;
    localparam int R = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic quant = 1'b0;
    logic above = 1'b0;
    logic mon_n;

    int checks = 0;
    int errors = 0;
    int phase  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    optmon_top #(.GAP_TICKS(G), .AMP_LOSS_TICKS(A), .RECOVER_TICKS(R)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .quant_i (quant),
        .above_i (above),
        .mon_n_o (mon_n)
    );

    // behavioural reference: delay lines plus "ticks since" integers
    bit m_d1, m_d2, m_d3, m_b1, m_b2, m_up;
    int m_since_tr, m_dark, m_run;
    bit m_chg, m_act, m_dim, m_ok;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_d1 = 0; m_d2 = 0; m_d3 = 0; m_b1 = 0; m_b2 = 0;
            m_up = 0; m_since_tr = G; m_dark = 0; m_run = 0;
        end else begin
            m_chg = (m_d2 != m_d3);
            m_act = (m_since_tr < G);
            m_dim = (m_dark >= A);
            m_ok  = m_act && m_b2;
            if (m_up) begin
                if (!m_act || m_dim) begin m_up = 0; m_run = 0; end
            end else if (m_ok) begin
                m_run++;
                if (m_run == R) begin m_up = 1; m_run = 0; end
            end else begin
                m_run = 0;
            end
            m_since_tr = m_chg ? 0 : ((m_since_tr < G) ? m_since_tr + 1 : G);
            m_dark     = m_b2 ? 0 : ((m_dark < A) ? m_dark + 1 : A);
            m_d3 = m_d2; m_d2 = m_d1; m_d1 = quant;
            m_b2 = m_b1; m_b1 = above;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (mon_n !== !m_up) begin
                errors++;
                $display("FAIL model R2 R4 R5 R6 at %0t: actual=%b expected=%b", $time, mon_n, !m_up);
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick(input int per, input bit abv);
        @(negedge clk);
        above = abv;
        phase++;
        if (per > 0 && (phase % per) == 0) quant = ~quant;
    endtask

    task automatic run(input int n, input int per, input bit abv);
        for (int i = 0; i < n; i++) tick(per, abv);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 in reset", mon_n, 1'b1);
        rst_n = 1'b1;
        run(3, 0, 1'b0);
        check("R1 after reset", mon_n, 1'b1);

        run(40, 4, 1'b1);
        check("R2 not yet qualified", mon_n, 1'b1);
        run(40, 4, 1'b1);
        check("R2 qualified", mon_n, 1'b0);

        run(60, 7, 1'b1);
        check("R3 wide spacing stays good", mon_n, 1'b0);

        // R4 exact no-light latency
        run(12, 4, 1'b1);
        @(negedge clk); quant = ~quant;
        for (int i = 0; i < G + 3; i++) @(negedge clk);
        check("R4 still good before latency", mon_n, 1'b0);
        @(negedge clk);
        check("R4 loss at latency", mon_n, 1'b1);

        run(70, 4, 1'b1);
        check("R2 requalified", mon_n, 1'b0);

        run(10, 4, 1'b0);
        run(10, 4, 1'b1);
        check("R5 short dip ignored", mon_n, 1'b0);

        // R5 exact low-light latency
        phase = 0;
        @(negedge clk); above = 1'b0;
        for (int i = 0; i < A + 2; i++) tick(4, 1'b0);
        check("R5 still good before latency", mon_n, 1'b0);
        tick(4, 1'b0);
        check("R5 loss at latency", mon_n, 1'b1);

        run(30, 4, 1'b1);
        run(3, 4, 1'b0);
        run(40, 4, 1'b1);
        check("R6 qualification restarted", mon_n, 1'b1);
        run(30, 4, 1'b1);
        check("R6 qualified after fresh run", mon_n, 1'b0);

        run(20, 0, 1'b1);
        check("R4 stopped transitions", mon_n, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule